// File: doc/BRIEF.md
# Processor Reset Sequencer with Cause Capture

This block drives reset lines for a four-processor system and remembers why the last reset happened. Software reaches it through a byte-wide register bus. One register requests a power-on style reset for chosen processors or for the whole machine. Another requests an externally initiated (warm) reset for chosen processors. Hardware request lines can also start a system reset or a warm reset: a watchdog, a push button, a JTAG controller, seven fatal-error reporters, a remote monitor and a clock-synthesizer reload. The watchdog line only acts when software has armed it.

There are two reset kinds, and each has its own pulse engine. An engine takes in all pending causes for its kind in one cycle and drives the selected outputs high for a fixed number of clocks. It then stores the whole cause vector in a sticky cause register. That register keeps its value through the reset it describes, and software reads it afterwards.

The register bus has no data stream. Writes complete in the cycle they are presented and reads return combinationally, so there is no valid/ready back-pressure. Every reset output is a plain active-high level.

Top module: `rstc_top`

## Requirements
- R1: Writing address 0 with any of bits 3:0 set pulses `cpu_por_o` for exactly those processors (bit n gives processor n). `sys_por_o` stays low, and bits 3:0 of the reset cause are set.
- R2: Writing address 0 with bit 4 set pulses all four `cpu_por_o` bits and `sys_por_o` together, and sets cause bit 4. Whenever `sys_por_o` is high, every `cpu_por_o` bit is high.
- R3: Writing address 1 with bits 3:0 pulses `cpu_xir_o` for those processors and loads them into warm-cause bits 3:0.
- R4: A software request bit clears itself in the cycle its pulse is started, so reading address 0 or 1 then returns 0.
- R5: Address 2 bit 0 arms the watchdog. When it is armed, a rising `wdog_i` starts a system reset with cause bit 16. When it is clear, a rising `wdog_i` produces no pulse and leaves the cause registers unchanged.
- R6: A rising edge on any of these lines starts a system reset: `jtag_por_i` (cause bit 5), `button_i` (bit 6), `fatal_i[k]` (bit 8+k) or `monitor_i` (bit 17).
- R7: Address 3 holds an arm bit (bit 7) and a load bit (bit 0). When both become 1, a system reset with cause bit 15 is started. The load bit alone does nothing.
- R8: A rising `jtag_xir_i` pulses all `cpu_xir_o` and sets warm-cause bit 4. A rising `xir_alarm_i` (watchdog or button warm request) does the same and sets warm-cause bit 5.
- R9: The 18-bit reset cause reads as bytes at addresses 4, 5 and 6, with bits 17:16 in bits 1:0 of address 6. The 6-bit warm cause reads at address 7. After reset they read 0x80/0x00/0x00 (power-up, bit 7) and 0x00. Each new event replaces the whole vector, recording every cause that is pending in the start cycle, and the value holds until the next event.
- R10: Each pulse lasts exactly 16 clocks. Hardware edges that arrive while a pulse of the same kind is running are dropped. Software requests stay pending and start a new pulse after the running one ends.
- R11: Reserved bits read as 0 and ignore writes: address 0 bits 7:5, address 1 bits 7:4, address 2 bits 7:1, and address 3 bits 6:1. Writes to addresses 4 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| jtag_por_i | input | 1 | JTAG system reset request |
| button_i | input | 1 | Push-button system reset request |
| fatal_i | input | 7 | Fatal-error reports, one per reporter |
| monitor_i | input | 1 | Remote monitor system reset request |
| wdog_i | input | 1 | Watchdog expiry line |
| jtag_xir_i | input | 1 | JTAG warm reset request to all processors |
| xir_alarm_i | input | 1 | Watchdog or button warm reset request to all processors |
| cpu_por_o | output | 4 | Per-processor power-on reset pulses |
| sys_por_o | output | 1 | System reset pulse |
| cpu_xir_o | output | 4 | Per-processor warm reset pulses |

## Verification
The bench checks that simultaneous causes are merged and recorded together. It writes processor 2's bit into the power-on request register and raises the push button so that both are seen at the same clock edge. The test passes only if one pulse covers every processor plus the system line and the cause reads 0x44. The second collision is a software request written while a pulse is already running, together with a JTAG edge in the same window. Afterwards the cause must name only the deferred software request, proving that the hardware edge was dropped and the soft bit waited.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NCPU    = 4;
  localparam int NFATAL  = 7;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int POR_W   = 18;
  localparam int XIR_W   = 6;
  localparam int PSOFT_W = NCPU + 1;
  localparam int NHW     = NFATAL + 7;

  // cause bit positions (software reads these)
  localparam int C_SOFTSYS = 4;
  localparam int C_JTAG    = 5;
  localparam int C_BUTTON  = 6;
  localparam int C_PWRUP   = 7;
  localparam int C_FATAL0  = 8;
  localparam int C_SYNTH   = 15;
  localparam int C_WDOG    = 16;
  localparam int C_MON     = 17;
  localparam int W_JTAG    = 4;
  localparam int W_ALARM   = 5;

  localparam logic [POR_W-1:0] POR_CAUSE_RST = POR_W'(1) << C_PWRUP;
  localparam logic [XIR_W-1:0] XIR_CAUSE_RST = '0;

  // hardware edge vector layout
  localparam int H_JXIR  = 0;
  localparam int H_ALARM = 1;
  localparam int H_JPOR  = 2;
  localparam int H_BTN   = 3;
  localparam int H_FAT0  = 4;
  localparam int H_SYN   = H_FAT0 + NFATAL;
  localparam int H_WDOG  = H_SYN + 1;
  localparam int H_MON   = H_WDOG + 1;

  typedef enum logic [ADDR_W-1:0] {
    A_PORREQ = 3'd0,
    A_XIRREQ = 3'd1,
    A_WDARM  = 3'd2,
    A_SYNTH  = 3'd3,
    A_PORC0  = 3'd4,
    A_PORC1  = 3'd5,
    A_PORC2  = 3'd6,
    A_XIRC   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/rstc_edge.sv
module rstc_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/rstc_pulse.sv
module rstc_pulse #(
  parameter int           CW        = 6,
  parameter int           MW        = 4,
  parameter int           LEN       = 16,
  parameter logic [CW-1:0] CAUSE_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] req_cause,
  input  logic [MW-1:0] req_mask,
  output logic [CW-1:0] cause_q,
  output logic [MW-1:0] pulse_o,
  output logic          take_o
);
  localparam int CNT_W = $clog2(LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [MW-1:0]    mask_q;
  logic             busy;

  assign busy   = (cnt != '0);
  assign take_o = !busy && (|req_cause);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cause_q <= CAUSE_RST;
      mask_q  <= '0;
    end else if (take_o) begin
      cnt     <= CNT_W'(LEN);
      cause_q <= req_cause;
      mask_q  <= req_mask;
    end else if (busy) begin
      cnt     <= cnt - 1'b1;
    end
  end

  assign pulse_o = busy ? mask_q : '0;
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs
  import rstc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 por_take,
  input  logic                 xir_take,
  input  logic [POR_W-1:0]     por_cause,
  input  logic [XIR_W-1:0]     xir_cause,
  output logic [PSOFT_W-1:0]   por_soft,
  output logic [NCPU-1:0]      xir_soft,
  output logic                 wd_en,
  output logic                 synth_lvl
);
  logic synth_arm, synth_load;
  logic wr_por, wr_xir, wr_wd, wr_syn;
  logic unused_wbits;

  assign wr_por = bus_wr && (bus_addr == A_PORREQ);
  assign wr_xir = bus_wr && (bus_addr == A_XIRREQ);
  assign wr_wd  = bus_wr && (bus_addr == A_WDARM);
  assign wr_syn = bus_wr && (bus_addr == A_SYNTH);
  assign unused_wbits = ^bus_wdata[6:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_soft   <= '0;
      xir_soft   <= '0;
      wd_en      <= 1'b0;
      synth_arm  <= 1'b0;
      synth_load <= 1'b0;
    end else begin
      por_soft <= (wr_por ? bus_wdata[PSOFT_W-1:0] : por_soft)
                  & ~(por_take ? por_soft : '0);
      xir_soft <= (wr_xir ? bus_wdata[NCPU-1:0] : xir_soft)
                  & ~(xir_take ? xir_soft : '0);
      if (wr_wd) wd_en <= bus_wdata[0];
      if (wr_syn) begin
        synth_arm  <= bus_wdata[DATA_W-1];
        synth_load <= bus_wdata[0];
      end
    end
  end

  assign synth_lvl = synth_arm && synth_load;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PORREQ: bus_rdata = DATA_W'(por_soft);
      A_XIRREQ: bus_rdata = DATA_W'(xir_soft);
      A_WDARM:  bus_rdata = DATA_W'(wd_en);
      A_SYNTH:  bus_rdata = {synth_arm, {(DATA_W-2){1'b0}}, synth_load};
      A_PORC0:  bus_rdata = por_cause[7:0];
      A_PORC1:  bus_rdata = por_cause[15:8];
      A_PORC2:  bus_rdata = DATA_W'(por_cause[POR_W-1:16]);
      A_XIRC:   bus_rdata = DATA_W'(xir_cause);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                jtag_por_i,
  input  logic                button_i,
  input  logic [NFATAL-1:0]   fatal_i,
  input  logic                monitor_i,
  input  logic                wdog_i,
  input  logic                jtag_xir_i,
  input  logic                xir_alarm_i,
  output logic [NCPU-1:0]     cpu_por_o,
  output logic                sys_por_o,
  output logic [NCPU-1:0]     cpu_xir_o
);
  logic [PSOFT_W-1:0] por_soft;
  logic [NCPU-1:0]    xir_soft;
  logic               wd_en, synth_lvl;
  logic [NHW-1:0]     hw_lvl, hw_rise;
  logic [POR_W-1:0]   por_req, por_cause;
  logic [XIR_W-1:0]   xir_req, xir_cause;
  logic [PSOFT_W-1:0] por_mask, por_pulse;
  logic [NCPU-1:0]    xir_mask;
  logic               por_take, xir_take, por_sys, xir_all;

  rstc_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .por_take(por_take), .xir_take(xir_take),
    .por_cause(por_cause), .xir_cause(xir_cause),
    .por_soft(por_soft), .xir_soft(xir_soft),
    .wd_en(wd_en), .synth_lvl(synth_lvl)
  );

  always_comb begin
    hw_lvl                          = '0;
    hw_lvl[H_JXIR]                  = jtag_xir_i;
    hw_lvl[H_ALARM]                 = xir_alarm_i;
    hw_lvl[H_JPOR]                  = jtag_por_i;
    hw_lvl[H_BTN]                   = button_i;
    hw_lvl[H_FAT0 +: NFATAL]        = fatal_i;
    hw_lvl[H_SYN]                   = synth_lvl;
    hw_lvl[H_WDOG]                  = wdog_i;
    hw_lvl[H_MON]                   = monitor_i;
  end

  rstc_edge #(.W(NHW)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(hw_lvl), .rise(hw_rise)
  );

  always_comb begin
    por_req                      = '0;
    por_req[PSOFT_W-1:0]         = por_soft;
    por_req[C_JTAG]              = hw_rise[H_JPOR];
    por_req[C_BUTTON]            = hw_rise[H_BTN];
    por_req[C_FATAL0 +: NFATAL]  = hw_rise[H_FAT0 +: NFATAL];
    por_req[C_SYNTH]             = hw_rise[H_SYN];
    por_req[C_WDOG]              = hw_rise[H_WDOG] && wd_en;
    por_req[C_MON]               = hw_rise[H_MON];
    xir_req                      = '0;
    xir_req[NCPU-1:0]            = xir_soft;
    xir_req[W_JTAG]              = hw_rise[H_JXIR];
    xir_req[W_ALARM]             = hw_rise[H_ALARM];
  end

  assign por_sys = |por_req[POR_W-1:C_SOFTSYS];
  assign xir_all = |xir_req[XIR_W-1:W_JTAG];

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    assign por_mask[g] = por_soft[g] | por_sys;
    assign xir_mask[g] = xir_soft[g] | xir_all;
  end
  assign por_mask[NCPU] = por_sys;

  rstc_pulse #(
    .CW(POR_W), .MW(PSOFT_W), .LEN(PULSE_LEN), .CAUSE_RST(POR_CAUSE_RST)
  ) u_por (
    .clk(clk), .rst_n(rst_n),
    .req_cause(por_req), .req_mask(por_mask),
    .cause_q(por_cause), .pulse_o(por_pulse), .take_o(por_take)
  );

  rstc_pulse #(
    .CW(XIR_W), .MW(NCPU), .LEN(PULSE_LEN), .CAUSE_RST(XIR_CAUSE_RST)
  ) u_xir (
    .clk(clk), .rst_n(rst_n),
    .req_cause(xir_req), .req_mask(xir_mask),
    .cause_q(xir_cause), .pulse_o(cpu_xir_o), .take_o(xir_take)
  );

  assign cpu_por_o = por_pulse[NCPU-1:0];
  assign sys_por_o = por_pulse[NCPU];
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk #(
  parameter int LEN = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cpu_por,
  input logic        sys_por,
  input logic [3:0]  cpu_xir,
  input logic [17:0] por_cause,
  input logic        por_take,
  input logic        wd_en
);
  localparam int HW = $clog2(LEN + 1) + 1;
  logic [HW-1:0] por_hc, xir_hc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_hc <= '0;
      xir_hc <= '0;
    end else begin
      por_hc <= (|cpu_por) ? por_hc + 1'b1 : '0;
      xir_hc <= (|cpu_xir) ? xir_hc + 1'b1 : '0;
    end
  end

  AST_SYS_ALL_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    sys_por |-> (&cpu_por)); // R2
  AST_POR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|cpu_por) |-> (por_hc == HW'(LEN))); // R10
  AST_XIR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|cpu_xir) |-> (xir_hc == HW'(LEN))); // R3
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(por_cause) |-> $past(por_take)); // R9
  AST_WDOG_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sys_por) && por_cause[16]) |-> $past(wd_en)); // R5
  AST_SYS_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_por) |-> (por_cause[17:4] != '0)); // R6
endmodule

bind rstc_top rstc_chk #(.LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_por(cpu_por_o), .sys_por(sys_por_o), .cpu_xir(cpu_xir_o),
  .por_cause(por_cause), .por_take(por_take), .wd_en(wd_en)
);

// File: tb/rstc_top_tb.sv
module rstc_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       jtag_por_i = 1'b0, button_i = 1'b0, monitor_i = 1'b0;
  logic       wdog_i = 1'b0, jtag_xir_i = 1'b0, xir_alarm_i = 1'b0;
  logic [6:0] fatal_i = '0;
  logic [3:0] cpu_por_o, cpu_xir_o;
  logic       sys_por_o;
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  rstc_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .jtag_por_i(jtag_por_i), .button_i(button_i), .fatal_i(fatal_i),
    .monitor_i(monitor_i), .wdog_i(wdog_i), .jtag_xir_i(jtag_xir_i),
    .xir_alarm_i(xir_alarm_i), .cpu_por_o(cpu_por_o),
    .sys_por_o(sys_por_o), .cpu_xir_o(cpu_xir_o)
  );

  // fields: addr[30:28] wdata[27:20] por[19:16] sys[15] xir[14:11] caddr[10:8] cause[7:0]
  localparam logic [30:0] VEC [8] = '{
    {3'd0, 8'h01, 4'h1, 1'b0, 4'h0, 3'd4, 8'h01},  // R1
    {3'd0, 8'h0A, 4'hA, 1'b0, 4'h0, 3'd4, 8'h0A},  // R1
    {3'd0, 8'h10, 4'hF, 1'b1, 4'h0, 3'd4, 8'h10},  // R2
    {3'd0, 8'h15, 4'hF, 1'b1, 4'h0, 3'd4, 8'h15},  // R2
    {3'd1, 8'h04, 4'h0, 1'b0, 4'h4, 3'd7, 8'h04},  // R3
    {3'd1, 8'h0F, 4'h0, 1'b0, 4'hF, 3'd7, 8'h0F},  // R3
    {3'd0, 8'hFF, 4'hF, 1'b1, 4'h0, 3'd4, 8'h1F},  // R11
    {3'd1, 8'hF3, 4'h0, 1'b0, 4'h3, 3'd7, 8'h03}   // R11
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic outs(input string tag, input logic [3:0] p, input logic s, input logic [3:0] x);
    chk(tag, {cpu_por_o, sys_por_o, cpu_xir_o}, {p, s, x});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input string tag, input int n);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (cpu_por_o != 0 || sys_por_o || cpu_xir_o != 0) seen++;
    end
    chk(tag, seen, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: got=%0d exp<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] c0, c1, c2;
    int hi;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R9 reset state
    outs("R9 reset outputs", 4'h0, 1'b0, 4'h0);
    rd(3'd4, d); chk("R9 reset cause byte0", d, 8'h80);
    rd(3'd5, d); chk("R9 reset cause byte1", d, 8'h00);
    rd(3'd6, d); chk("R9 reset cause byte2", d, 8'h00);
    rd(3'd7, d); chk("R9 reset warm cause", d, 8'h00);

    // vector table
    for (int i = 0; i < 8; i++) begin
      logic [30:0] v;
      v = VEC[i];
      wr(v[30:28], v[27:20]);
      @(negedge clk);
      outs($sformatf("R1/R2/R3 vec%0d outputs", i), v[19:16], v[15], v[14:11]);
      rd(v[10:8], d); chk($sformatf("R9 vec%0d cause", i), d, {24'h0, v[7:0]});
      rd(v[30:28], d); chk($sformatf("R4 vec%0d self clear", i), d, 8'h00);
      idle(20);
      outs($sformatf("R10 vec%0d ended", i), 4'h0, 1'b0, 4'h0);
    end

    // R10 pulse width
    wr(3'd0, 8'h02);
    hi = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (cpu_por_o[1]) hi++;
    end
    chk("R10 pulse width", hi, 16);

    // R5 watchdog disarmed
    rd(3'd4, c0); rd(3'd5, c1); rd(3'd6, c2);
    @(negedge clk); wdog_i = 1'b1;
    idle(2); wdog_i = 1'b0;
    quiet("R5 disarmed no pulse", 20);
    rd(3'd4, d); chk("R5 disarmed cause0", d, c0);
    rd(3'd5, d); chk("R5 disarmed cause1", d, c1);
    rd(3'd6, d); chk("R5 disarmed cause2", d, c2);

    // R5 watchdog armed
    wr(3'd2, 8'hFF);
    rd(3'd2, d); chk("R11 arm reserved", d, 8'h01);
    wdog_i = 1'b1;
    @(negedge clk);
    outs("R5 armed pulse", 4'hF, 1'b1, 4'h0);
    rd(3'd6, d); chk("R5 cause bit16", d, 8'h01);
    rd(3'd4, d); chk("R9 full replace byte0", d, 8'h00);
    wdog_i = 1'b0; idle(20);

    // R6 hardware sources
    jtag_por_i = 1'b1; @(negedge clk);
    outs("R6 jtag pulse", 4'hF, 1'b1, 4'h0);
    rd(3'd4, d); chk("R6 jtag cause", d, 8'h20);
    jtag_por_i = 1'b0; idle(20);
    button_i = 1'b1; @(negedge clk);
    rd(3'd4, d); chk("R6 button cause", d, 8'h40);
    button_i = 1'b0; idle(20);
    fatal_i = 7'b0001000; @(negedge clk);
    outs("R6 fatal pulse", 4'hF, 1'b1, 4'h0);
    rd(3'd5, d); chk("R6 fatal3 cause", d, 8'h08);
    fatal_i = '0; idle(20);
    monitor_i = 1'b1; @(negedge clk);
    rd(3'd6, d); chk("R6 monitor cause", d, 8'h02);
    monitor_i = 1'b0; idle(20);

    // R7 synthesizer reload
    wr(3'd3, 8'h01);
    quiet("R7 load alone", 20);
    wr(3'd3, 8'hFF);
    @(negedge clk);
    outs("R7 synth pulse", 4'hF, 1'b1, 4'h0);
    rd(3'd5, d); chk("R7 synth cause", d, 8'h80);
    rd(3'd3, d); chk("R11 synth reserved", d, 8'h81);
    idle(20);
    wr(3'd3, 8'h00);

    // R8 warm hardware sources
    jtag_xir_i = 1'b1; @(negedge clk);
    outs("R8 jtag warm", 4'h0, 1'b0, 4'hF);
    rd(3'd7, d); chk("R8 jtag warm cause", d, 8'h10);
    jtag_xir_i = 1'b0; idle(20);
    xir_alarm_i = 1'b1; @(negedge clk);
    outs("R8 alarm warm", 4'h0, 1'b0, 4'hF);
    rd(3'd7, d); chk("R8 alarm warm cause", d, 8'h20);
    xir_alarm_i = 1'b0; idle(20);

    // R9 simultaneous soft request and button
    wr(3'd0, 8'h04);
    button_i = 1'b1;
    @(negedge clk);
    outs("R9 merged pulse", 4'hF, 1'b1, 4'h0);
    rd(3'd4, d); chk("R9 merged cause", d, 8'h44);
    button_i = 1'b0; idle(20);

    // R10 requests during a running pulse
    wr(3'd0, 8'h01);
    idle(3);
    wr(3'd0, 8'h02);
    jtag_por_i = 1'b1;
    hi = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (hi == 0 && cpu_por_o == 4'b0010) begin
        hi = 1;
        chk("R10 deferred soft sys low", sys_por_o, 1'b0);
        rd(3'd4, d); chk("R10 jtag dropped cause", d, 8'h02);
      end
    end
    chk("R10 deferred soft pulse", hi, 1);
    jtag_por_i = 1'b0; idle(20);

    // R11 cause registers ignore writes
    rd(3'd4, c0);
    wr(3'd4, 8'hFF);
    wr(3'd7, 8'hFF);
    rd(3'd4, d); chk("R11 cause write ignored", d, c0);
    rd(3'd7, d); chk("R11 warm cause write ignored", d, 8'h20);
    quiet("R11 no pulse from cause write", 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule